// File: doc/BRIEF.md
# Energy Code Frame Broadcaster

This block takes a 16-bit beam energy sample from an upstream stream, reduces it to a 5-bit energy code through a lookup table set by parameter, and builds a 16-bit composite word. The word carries the code and a set of status and test-command flags for the downstream threshold-comparator cards. Each frame tick starts one 32-bit serial frame: an 8-bit header, the composite word, a toggle nibble and a CRC-4. The frame is driven one bit per clock on every receiver lane at once.

When the upstream energy link is reported broken, the block sends a fixed fallback word instead of the live data. In test mode the host may replace the looked-up energy code with a value of its own. A frame's fields are captured when the frame starts, so the frame always sends one consistent word.

The energy input is a valid/ready stream. `eng_ready` is high whenever the block is out of reset, so the upstream side never sees back-pressure. Each accepted sample replaces the held energy, and the held energy is used by the next frame that starts after the sample is accepted. All other inputs are plain levels. They are sampled in the clock cycle where a tick starts a frame.

Top module: `energy_bcast_top`

## Requirements
- R1: The energy code is the number of table thresholds T1..T31 (ascending, 16 bits each, entry i at bits [16*i +: 16] of `THR_TABLE`) that the held energy is greater than or equal to, giving 0 to 31.
- R2: In normal operation the composite word is {code[4:0], err_flag, tc_soft_rst, sys_test, ubeam_info, mbeam_info, uline_test, mline_test, card_sel[3:0]}, from bit 15 down to bit 0.
- R3: A tick sampled high while no frame is running starts a frame. From the next cycle, 32 bits are sent MSB first, one per clock: header 8'b10010000, the composite word, the toggle bit followed by 3'b000, then the CRC. `frame_act` is high for exactly those 32 cycles. Every lane is 0 while no frame is running.
- R4: All NUM_RX lanes of `ser_out` carry the same bit in every cycle.
- R5: When `link_broken` is high at frame start, the word is {5'd31, 8'b10011000, card_sel[2:0]}, whatever the energy, override and flag inputs are.
- R6: The code is replaced by `ovr_code` only when `test_mode` and `ovr_en` are both high and the link is not broken. Otherwise `ovr_code` has no effect.
- R7: The toggle bit inverts on every frame. The first frame after reset carries toggle 1.
- R8: A tick that arrives during a frame is ignored: the running frame is not changed or restarted, and the toggle does not advance.
- R9: The CRC uses the polynomial x^4+x+1, starts from 0, and is computed MSB first over the first 28 frame bits.
- R10: `eng_ready` is high out of reset. An accepted sample replaces the held energy, and the held energy is 0 after reset.
- R11: After reset, `frame_act` and all lanes are 0 and no frame runs until a tick arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_valid | input | 1 | Energy sample valid |
| eng_ready | output | 1 | Energy sample accepted |
| eng_data | input | 16 | Energy sample |
| frame_tick | input | 1 | Frame start request |
| link_broken | input | 1 | Upstream energy link lost |
| test_mode | input | 1 | Test mode enable |
| ovr_en | input | 1 | Replace energy code with override |
| ovr_code | input | 5 | Override energy code |
| err_flag | input | 1 | Error flag for the word |
| tc_soft_rst | input | 1 | Soft reset command to comparator cards |
| sys_test | input | 1 | System-under-test flag |
| ubeam_info | input | 1 | Unmaskable beam information |
| mbeam_info | input | 1 | Maskable beam information |
| uline_test | input | 1 | Unmaskable line test activation |
| mline_test | input | 1 | Maskable line test activation |
| card_sel | input | 4 | Comparator card under test |
| frame_act | output | 1 | Frame in progress |
| ser_out | output | NUM_RX | Serial frame, one lane per receiver |

## Verification
The bench builds the block with NUM_RX = 4 and a quadratic threshold table (Ti = 64·i²). This table has uneven step widths, so a lookup that only shifts the energy or is off by one index gives visibly wrong codes. Directed energies sit exactly on a threshold and one below it, and also at 0 and 65535. Random frames mix the broken-link, test-mode and override inputs, and one frame receives a tick in the middle to show that it is neither restarted nor given an extra toggle.

// File: rtl/energy_bcast_pkg.sv
package energy_bcast_pkg;
  localparam int WORD_W  = 16;
  localparam int CODE_W  = 5;
  localparam int NUM_THR = 31;
  localparam int FRAME_W = 32;
  localparam int CRC_W   = 4;
  localparam int CRC_SPAN = FRAME_W - CRC_W;
  localparam int TAB_W   = WORD_W * (NUM_THR + 1);
  localparam logic [7:0] HEADER     = 8'b1001_0000;
  localparam logic [7:0] BROKEN_MID = 8'b1001_1000;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

  typedef struct packed {
    logic       err;
    logic       srst;
    logic       sut;
    logic       ubi;
    logic       mbi;
    logic       utst;
    logic       mtst;
    logic [3:0] card;
  } ctl_t;

  function automatic logic [CRC_W-1:0] crc4_calc(input logic [CRC_SPAN-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = CRC_SPAN - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  function automatic logic [TAB_W-1:0] linear_table(input int step);
    logic [TAB_W-1:0] t;
    t = '0;
    for (int i = 1; i <= NUM_THR; i++) t[i*WORD_W +: WORD_W] = WORD_W'(i * step);
    return t;
  endfunction
endpackage

// File: rtl/energy_lut.sv
module energy_lut
  import energy_bcast_pkg::*;
#(
  parameter logic [TAB_W-1:0] THR_TABLE = linear_table(2048)
) (
  input  logic [WORD_W-1:0] energy,
  output logic [CODE_W-1:0] code
);
  logic [NUM_THR:1] ge;

  genvar g;
  generate
    for (g = 1; g <= NUM_THR; g++) begin : g_cmp
      assign ge[g] = (energy >= THR_TABLE[g*WORD_W +: WORD_W]);
    end
  endgenerate

  always_comb begin
    code = '0;
    for (int i = 1; i <= NUM_THR; i++) code = code + CODE_W'(ge[i]);
  end
endmodule

// File: rtl/word_pack.sv
module word_pack
  import energy_bcast_pkg::*;
(
  input  logic [CODE_W-1:0] lut_code,
  input  logic              link_broken,
  input  logic              test_mode,
  input  logic              ovr_en,
  input  logic [CODE_W-1:0] ovr_code,
  input  ctl_t              ctl,
  output logic [WORD_W-1:0] word
);
  logic [CODE_W-1:0] sel_code;

  always_comb begin
    sel_code = (test_mode && ovr_en) ? ovr_code : lut_code;
    if (link_broken)
      word = {{CODE_W{1'b1}}, BROKEN_MID, ctl.card[2:0]};
    else
      word = {sel_code, ctl};
  end
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import energy_bcast_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [WORD_W-1:0] word,
  output logic              start,
  output logic              active,
  output logic              tx_bit
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic               tog;
  logic               tog_n;
  logic [CRC_SPAN-1:0] body;

  assign start = tick && !active;
  assign tog_n = ~tog;
  assign body  = {HEADER, word, tog_n, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      cnt    <= '0;
      tog    <= 1'b0;
      active <= 1'b0;
    end else if (start) begin
      sh     <= {body, crc4_calc(body)};
      cnt    <= CNT_W'(FRAME_W - 1);
      tog    <= tog_n;
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) begin
        active <= 1'b0;
      end else begin
        sh  <= {sh[FRAME_W-2:0], 1'b0};
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign tx_bit = active & sh[FRAME_W-1];

  AST_HEADER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && tx_bit)); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tog != $past(tog))); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(tog)); // R8
endmodule

// File: rtl/energy_bcast_top.sv
module energy_bcast_top
  import energy_bcast_pkg::*;
#(
  parameter int NUM_RX = 16,
  parameter logic [TAB_W-1:0] THR_TABLE = linear_table(2048)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_valid,
  output logic              eng_ready,
  input  logic [WORD_W-1:0] eng_data,
  input  logic              frame_tick,
  input  logic              link_broken,
  input  logic              test_mode,
  input  logic              ovr_en,
  input  logic [CODE_W-1:0] ovr_code,
  input  logic              err_flag,
  input  logic              tc_soft_rst,
  input  logic              sys_test,
  input  logic              ubeam_info,
  input  logic              mbeam_info,
  input  logic              uline_test,
  input  logic              mline_test,
  input  logic [3:0]        card_sel,
  output logic              frame_act,
  output logic [NUM_RX-1:0] ser_out
);
  logic [WORD_W-1:0] energy_q;
  logic [CODE_W-1:0] lut_code;
  logic [WORD_W-1:0] pack_word;
  logic              start;
  logic              tx_bit;
  ctl_t              ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_ready <= 1'b0;
      energy_q  <= '0;
    end else begin
      eng_ready <= 1'b1;
      if (eng_valid && eng_ready) energy_q <= eng_data;
    end
  end

  assign ctl = '{err: err_flag, srst: tc_soft_rst, sut: sys_test, ubi: ubeam_info,
                 mbi: mbeam_info, utst: uline_test, mtst: mline_test, card: card_sel};

  energy_lut #(.THR_TABLE(THR_TABLE)) i_lut (
    .energy (energy_q),
    .code   (lut_code)
  );

  word_pack i_pack (
    .lut_code    (lut_code),
    .link_broken (link_broken),
    .test_mode   (test_mode),
    .ovr_en      (ovr_en),
    .ovr_code    (ovr_code),
    .ctl         (ctl),
    .word        (pack_word)
  );

  frame_tx i_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (frame_tick),
    .word   (pack_word),
    .start  (start),
    .active (frame_act),
    .tx_bit (tx_bit)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_RX; g++) begin : g_lane
      assign ser_out[g] = tx_bit;
    end
  endgenerate

  AST_BROKEN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && link_broken) |-> (pack_word[15:11] == 5'd31 && pack_word[10:3] == BROKEN_MID)); // R5
  AST_OVR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !link_broken && !test_mode) |-> (pack_word[15:11] == lut_code)); // R6
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |-> (ser_out == '0)); // R3
endmodule

// File: tb/test_energy_bcast_top.sv
module test_energy_bcast_top;
  import energy_bcast_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NRX = 4;

  function automatic logic [TAB_W-1:0] quad_table();
    logic [TAB_W-1:0] t;
    t = '0;
    for (int i = 1; i <= 31; i++) t[i*16 +: 16] = 16'(i * i * 64);
    return t;
  endfunction

  logic clk = 0, rst_n = 0;
  logic eng_valid = 0, eng_ready;
  logic [15:0] eng_data = 0;
  logic frame_tick = 0, link_broken = 0, test_mode = 0, ovr_en = 0;
  logic [4:0] ovr_code = 0;
  logic err_flag = 0, tc_soft_rst = 0, sys_test = 0, ubeam_info = 0, mbeam_info = 0;
  logic uline_test = 0, mline_test = 0;
  logic [3:0] card_sel = 0;
  logic frame_act;
  logic [NRX-1:0] ser_out;

  int n_run = 0, n_fail = 0;
  logic tb_tog = 0;
  logic [15:0] tb_energy = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  energy_bcast_top #(.NUM_RX(NRX), .THR_TABLE(quad_table())) i_energy_bcast_top (
    .clk, .rst_n, .eng_valid, .eng_ready, .eng_data, .frame_tick, .link_broken,
    .test_mode, .ovr_en, .ovr_code, .err_flag, .tc_soft_rst, .sys_test, .ubeam_info,
    .mbeam_info, .uline_test, .mline_test, .card_sel, .frame_act, .ser_out);

  function automatic logic [4:0] exp_code(input logic [15:0] e);
    int c = 0;
    for (int i = 1; i <= 31; i++) if (int'(e) >= i * i * 64) c++;
    return 5'(c);
  endfunction

  function automatic logic [3:0] exp_crc(input logic [27:0] d);
    logic [3:0] c = 0;
    logic fb;
    for (int i = 27; i >= 0; i--) begin
      fb = c[3] ^ d[i];
      c = {c[2:0], 1'b0};
      if (fb) c = c ^ 4'b0011;
    end
    return c;
  endfunction

  function automatic logic [15:0] exp_word();
    logic [4:0] cd;
    if (link_broken) return {5'd31, 8'b10011000, card_sel[2:0]};
    cd = (test_mode && ovr_en) ? ovr_code : exp_code(tb_energy);
    return {cd, err_flag, tc_soft_rst, sys_test, ubeam_info, mbeam_info,
            uline_test, mline_test, card_sel};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_energy(input logic [15:0] e);
    @(negedge clk);
    eng_valid = 1; eng_data = e;
    chk("R10 ready", {31'd0, eng_ready}, 32'd1);
    @(negedge clk);
    eng_valid = 0;
    tb_energy = e;
  endtask

  // mid_tick: raise the tick for one cycle in the middle of the frame
  task automatic run_frame(input string req, input bit mid_tick);
    logic [31:0] got, exp;
    logic [27:0] body;
    bit lane_bad = 0, act_bad = 0;
    tb_tog = ~tb_tog;
    body = {8'b10010000, exp_word(), tb_tog, 3'b000};
    exp = {body, exp_crc(body)};
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
    for (int k = 31; k >= 0; k--) begin
      if (k != 31) @(negedge clk);
      frame_tick = (mid_tick && k == 15);
      got[k] = ser_out[0];
      if (ser_out !== {NRX{ser_out[0]}}) lane_bad = 1;
      if (frame_act !== 1'b1) act_bad = 1;
    end
    @(negedge clk);
    frame_tick = 0;
    chk(req, got, exp);
    chk("R4 lanes equal", {31'd0, lane_bad}, 32'd0);
    chk("R3 frame_act span", {31'd0, act_bad}, 32'd0);
    chk("R3 idle after frame", {27'd0, frame_act, ser_out}, 32'd0);
  endtask

  task automatic clear_ctl();
    link_broken = 0; test_mode = 0; ovr_en = 0; ovr_code = 0;
    {err_flag, tc_soft_rst, sys_test, ubeam_info, mbeam_info, uline_test, mline_test} = '0;
    card_sel = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset state", {27'd0, frame_act, ser_out}, 32'd0);
    repeat (5) @(negedge clk);
    chk("R11 no frame without tick", {27'd0, frame_act, ser_out}, 32'd0);

    // reset energy is 0, first toggle 1
    run_frame("R10 R7 first frame energy 0", 0);
    // threshold boundaries
    card_sel = 4'hA; err_flag = 1; ubeam_info = 1;
    set_energy(16'd64);  run_frame("R1 exact T1", 0);
    set_energy(16'd63);  run_frame("R1 below T1", 0);
    set_energy(16'(25*64)); run_frame("R1 exact T5", 0);
    set_energy(16'(25*64-1)); run_frame("R1 below T5", 0);
    set_energy(16'(31*31*64)); run_frame("R1 exact T31", 0);
    set_energy(16'hFFFF); run_frame("R1 max energy", 0);
    // layout with every flag
    {err_flag, tc_soft_rst, sys_test, ubeam_info, mbeam_info, uline_test, mline_test} = 7'b1010101;
    card_sel = 4'h5; run_frame("R2 flag layout", 0);
    {err_flag, tc_soft_rst, sys_test, ubeam_info, mbeam_info, uline_test, mline_test} = 7'b0101010;
    card_sel = 4'hE; run_frame("R2 R9 alt flags", 0);
    // override gating
    ovr_en = 1; ovr_code = 5'd3; test_mode = 0; run_frame("R6 override without test mode", 0);
    test_mode = 1; run_frame("R6 override in test mode", 0);
    // broken link wins
    link_broken = 1; card_sel = 4'hF; run_frame("R5 broken link with override", 0);
    clear_ctl(); link_broken = 1; set_energy(16'd0); run_frame("R5 broken link energy 0", 0);
    clear_ctl();
    // tick during frame
    set_energy(16'd5000); run_frame("R8 tick during frame", 0);
    run_frame("R8 R7 mid tick ignored", 1);
    run_frame("R7 toggle after mid tick", 0);

    for (int n = 0; n < 40; n++) begin
      if ($urandom % 2) set_energy(16'($urandom));
      link_broken = ($urandom % 5) == 0;
      test_mode = $urandom % 2; ovr_en = $urandom % 2; ovr_code = 5'($urandom);
      {err_flag, tc_soft_rst, sys_test, ubeam_info, mbeam_info, uline_test, mline_test} = 7'($urandom);
      card_sel = 4'($urandom);
      run_frame("R1 R2 R5 R6 R9 random frame", 0);
      repeat ($urandom % 4) @(negedge clk);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule